// File: doc/BRIEF.md
# ADC Result Window Detector

This block sits beside an analog-to-digital converter and checks every new conversion result against two programmable 16-bit limits: a greater-than limit and a less-than limit. When a result meets the programmed condition, it sets a sticky flag. It also raises a single-cycle interrupt request if interrupts are enabled. Software can either take the interrupt or poll the flag, and it clears the flag through a dedicated clear control.

There is no mode bit. The ordering of the two limits selects the test. When the less-than limit is larger than the greater-than limit, the block detects results strictly inside the window. In every other case it detects results outside the window. Both boundaries are strict.

Right-justified and left-justified results work the same way, provided the limits use the same justification. For example, a 10-bit value shifted up by six bits is compared against limits that are also shifted up by six bits.

Top module: `adc_win_det`

## Requirements
- R1: During and directly after reset (`rst_ni` low), `win_flag_o` and `irq_o` are 0.
- R2: When `lim_lt_i > lim_gt_i` (inside test), a result is a hit only if `lim_gt_i < res_data_i < lim_lt_i`, using unsigned comparison. For example, with limits 0x0040 and 0x0080, only results 65 to 127 hit.
- R3: When `lim_lt_i <= lim_gt_i` (outside test), a result is a hit if `res_data_i < lim_lt_i` or `res_data_i > lim_gt_i`. For example, with lt=0x0040 and gt=0x0080, results 0 to 63 and 129 and above hit.
- R4: A result equal to either limit is never a hit, whichever test is active.
- R5: A result is evaluated only in a cycle where `res_valid_i` is 1. The data word has no effect while `res_valid_i` is 0.
- R6: A hit sets `win_flag_o` on the next clock edge. The flag stays at 1 until a cycle with `flag_clr_i` at 1 and no hit, after which it reads 0 on the next edge.
- R7: If a clear and a hit occur in the same cycle, `win_flag_o` is 1 after the edge.
- R8: `irq_o` is 1 for exactly the one cycle following a hit, provided `irq_en_i` was 1 in the hit cycle. Otherwise `irq_o` stays 0, although the flag is still set.
- R9: Hits in consecutive cycles produce `irq_o` at 1 in each of the following cycles, one pulse per hit.
- R10: Left-justified data is handled the same way. A 10-bit value shifted left by 6 bits, compared against limits also shifted left by 6 bits, gives the same hit result as the unshifted value against the unshifted limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Strobe marking a new conversion result |
| res_data_i | input | 16 | Conversion result word |
| lim_gt_i | input | 16 | Greater-than limit |
| lim_lt_i | input | 16 | Less-than limit |
| flag_clr_i | input | 1 | Clears the sticky flag |
| irq_en_i | input | 1 | Interrupt enable |
| win_flag_o | output | 1 | Sticky window flag |
| irq_o | output | 1 | One-cycle interrupt request per hit |

## Verification
The hardest cases to reach from the ports are the boundaries between the two tests. These are equal limits and results sitting exactly on a limit, where the inside test, the outside test and strictness all meet. The bench holds the clear control high while streaming a new valid result every cycle, so the flag after each edge reflects that single result alone. Under this scheme it sweeps every data value against every pair of limits in a small 4-bit range, including all equal-limit pairs. It then sweeps the full 10-bit range in both limit orders, in both justifications.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
  parameter int unsigned DW = 16;
  typedef logic [DW-1:0] word_t;
  typedef enum logic {WIN_OUTSIDE = 1'b0, WIN_INSIDE = 1'b1} win_mode_e;
endpackage

// File: rtl/adc_win_cmp.sv
module adc_win_cmp #(
  parameter int unsigned DW = adc_win_pkg::DW
) (
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] gt_i,
  input  logic [DW-1:0] lt_i,
  output logic          hit_o
);
  import adc_win_pkg::*;

  logic      above_gt, below_lt;
  win_mode_e mode;

  always_comb begin
    above_gt = data_i > gt_i;
    below_lt = data_i < lt_i;
    // limit order picks the test
    mode     = (lt_i > gt_i) ? WIN_INSIDE : WIN_OUTSIDE;
    unique case (mode)
      WIN_INSIDE:  hit_o = valid_i & above_gt & below_lt;
      WIN_OUTSIDE: hit_o = valid_i & (above_gt | below_lt);
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_win_flag.sv
module adc_win_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // set wins over clear
      flag_q <= hit_i | (flag_q & ~clr_i);
      irq_q  <= hit_i & irq_en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/adc_win_det.sv
module adc_win_det #(
  parameter int unsigned DW = adc_win_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_data_i,
  input  logic [DW-1:0] lim_gt_i,
  input  logic [DW-1:0] lim_lt_i,
  input  logic          flag_clr_i,
  input  logic          irq_en_i,
  output logic          win_flag_o,
  output logic          irq_o
);
  logic hit_w;

  adc_win_cmp #(.DW(DW)) i_cmp (
    .valid_i(res_valid_i),
    .data_i (res_data_i),
    .gt_i   (lim_gt_i),
    .lt_i   (lim_lt_i),
    .hit_o  (hit_w)
  );

  adc_win_flag i_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_w),
    .clr_i   (flag_clr_i),
    .irq_en_i(irq_en_i),
    .flag_o  (win_flag_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/adc_win_det_chk.sv
module adc_win_det_chk #(
  parameter int unsigned DW = adc_win_pkg::DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          res_valid_i,
  input logic [DW-1:0] res_data_i,
  input logic [DW-1:0] lim_gt_i,
  input logic [DW-1:0] lim_lt_i,
  input logic          flag_clr_i,
  input logic          irq_en_i,
  input logic          win_flag_o,
  input logic          irq_o,
  input logic          hit_i
);
  assert_inside_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && lim_lt_i > lim_gt_i && res_data_i > lim_gt_i && res_data_i < lim_lt_i)
      |=> win_flag_o);

  assert_outside_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && lim_lt_i <= lim_gt_i && (res_data_i < lim_lt_i || res_data_i > lim_gt_i))
      |=> win_flag_o);

  assert_equal_no_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && (res_data_i == lim_gt_i || res_data_i == lim_lt_i)) |=> !win_flag_o);

  assert_no_valid_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !win_flag_o) |=> !win_flag_o);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_flag_o && !flag_clr_i) |=> win_flag_o);

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !res_valid_i) |=> !win_flag_o);

  assert_clear_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && hit_i) |=> win_flag_o);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o);

  assert_irq_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> win_flag_o);

  assert_irq_each_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && irq_en_i) |=> irq_o);
endmodule

bind adc_win_det adc_win_det_chk #(.DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .res_valid_i(res_valid_i),
  .res_data_i (res_data_i),
  .lim_gt_i   (lim_gt_i),
  .lim_lt_i   (lim_lt_i),
  .flag_clr_i (flag_clr_i),
  .irq_en_i   (irq_en_i),
  .win_flag_o (win_flag_o),
  .irq_o      (irq_o),
  .hit_i      (hit_w)
);

// File: tb/test_adc_win_det.sv
module test_adc_win_det;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] gt = '0;
  logic [DW-1:0] lt = '0;
  logic          clr = 1'b0;
  logic          en = 1'b0;
  logic          flag, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adc_win_det i_adc_win_det (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(data),
    .lim_gt_i(gt), .lim_lt_i(lt), .flag_clr_i(clr), .irq_en_i(en),
    .win_flag_o(flag), .irq_o(irq)
  );

  function automatic bit exp_hit(int unsigned d, int unsigned g, int unsigned l);
    if (l > g) return (d > g) && (d < l);
    return (d < l) || (d > g);
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0b exp=%0b data=%0h gt=%0h lt=%0h", req, act, exp, data, gt, lt);
    end
  endtask

  // drive at negedge, sample 5 ns after the next posedge
  task automatic step(logic v, logic [DW-1:0] d, logic c, logic e);
    @(negedge clk);
    valid = v; data = d; clr = c; en = e;
    @(posedge clk);
    #5;
  endtask

  // one result with clear held: outputs reflect this result only
  task automatic probe(string req, int unsigned d, int unsigned g, int unsigned l);
    bit h;
    @(negedge clk);
    gt = DW'(g); lt = DW'(l);
    step(1'b1, DW'(d), 1'b1, 1'b1);
    h = exp_hit(d, g, l);
    check(req, flag, h);
    check({req, "_irq"}, irq, h);
  endtask

  initial begin
    #40000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #35;
    check("R1", flag, 1'b0);
    check("R1", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1", flag, 1'b0);
    check("R1", irq, 1'b0);

    // R2 R3 R4: exhaustive over 4-bit limits and data, equal limits included
    for (int g = 0; g < 16; g++)
      for (int l = 0; l < 16; l++)
        for (int d = 0; d < 16; d++)
          probe((l > g) ? "R2_R4" : "R3_R4", d, g, l);

    // R2 R3: 10-bit right-justified, limits 0x40 / 0x80
    for (int d = 0; d < 1024; d++) probe("R2", d, 'h40, 'h80);
    for (int d = 0; d < 1024; d++) probe("R3", d, 'h80, 'h40);
    // R10: left-justified, same limits shifted
    for (int d = 0; d < 1024; d++) probe("R10", d << 6, 'h40 << 6, 'h80 << 6);
    for (int d = 0; d < 1024; d++) probe("R10", d << 6, 'h80 << 6, 'h40 << 6);

    // R5: invalid strobes with matching data never set
    @(negedge clk); gt = 16'h0040; lt = 16'h0080;
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    check("R5", flag, 1'b0);
    step(1'b0, 16'h0060, 1'b0, 1'b1);
    check("R5", flag, 1'b0);
    check("R5", irq, 1'b0);
    step(1'b0, 16'h0061, 1'b0, 1'b1);
    check("R5", flag, 1'b0);

    // R6: set, hold with stale data, then clear
    step(1'b1, 16'h0050, 1'b0, 1'b1);
    check("R6", flag, 1'b1);
    check("R8", irq, 1'b1);
    step(1'b0, 16'h0050, 1'b0, 1'b1);
    check("R6", flag, 1'b1);
    check("R8", irq, 1'b0);
    step(1'b1, 16'h0010, 1'b0, 1'b1);
    check("R6", flag, 1'b1);
    step(1'b0, 16'h0050, 1'b1, 1'b1);
    check("R6", flag, 1'b0);

    // R7: set, then clear with a coinciding hit
    step(1'b1, 16'h0070, 1'b0, 1'b1);
    check("R7", flag, 1'b1);
    step(1'b1, 16'h0041, 1'b1, 1'b1);
    check("R7", flag, 1'b1);
    check("R7", irq, 1'b1);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    check("R7", flag, 1'b0);

    // R8: enable low, flag sets but no request
    step(1'b1, 16'h0060, 1'b0, 1'b0);
    check("R8", flag, 1'b1);
    check("R8", irq, 1'b0);
    step(1'b0, 16'h0000, 1'b1, 1'b1);

    // R9: back-to-back hits, then a miss
    step(1'b1, 16'h0045, 1'b0, 1'b1);
    check("R9", irq, 1'b1);
    step(1'b1, 16'h0046, 1'b0, 1'b1);
    check("R9", irq, 1'b1);
    step(1'b1, 16'h0047, 1'b0, 1'b1);
    check("R9", irq, 1'b1);
    step(1'b1, 16'h0080, 1'b0, 1'b1);
    check("R9", irq, 1'b0);
    check("R9", flag, 1'b1);

    // R1: asynchronous reset clears a set flag
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R1", flag, 1'b0);
    check("R1", irq, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule